// File: doc/BRIEF.md
# Two-Stage Fetch Front End with Control-Flow Flush

This block is the front half of a two-stage integer pipeline. Stage 1 owns the fetch program counter. It presents that counter as the instruction-memory address and accepts the instruction word returned in the same cycle. On each clock edge a forward pipeline register hands the fetched word and its own fetch address to stage 2. Stage 2 decodes, executes, accesses memory and writes back in one cycle, and uses the PC copy held in that register for branch targets, PC-relative adds and link values.

Stage 2 feeds two signals back without registering them: the outcome of its branch comparison and the 32-bit control-flow target. The block looks at the major opcode of the word now in stage 2. If that word is a jump, or a conditional branch whose comparison succeeded, the block loads the target into the fetch PC. On the same edge it discards the word just fetched and places the canonical no-op (an add-immediate of zero into register zero) into stage 2. It adds no stalls and no forwarding.

Top module: `fe2_pipe_front`

## Requirements
- R1: While reset is low, the fetch address is RESET_PC (0 by default), the stage-2 PC is 0 and the stage-2 instruction is the no-op 0x00000013.
- R2: When no redirect occurs, each edge adds 4 to the fetch address. The stage-2 instruction takes the word that was returned for the old fetch address, and the stage-2 PC takes that old address.
- R3: When the stage-2 opcode (bits 6:0) is 0x6F or 0x67, the next edge loads the fetch address from the target and places 0x00000013 into stage 2, whatever the branch outcome is.
- R4: When the stage-2 opcode is 0x63 and the branch outcome input is 1, the next edge loads the target into the fetch address and places 0x00000013 into stage 2.
- R5: When the stage-2 opcode is 0x63 and the branch outcome input is 0, the fetch address advances by 4 and the fetched word enters stage 2 unchanged.
- R6: For any stage-2 opcode other than 0x63, 0x6F and 0x67, the branch outcome input has no effect on the fetch address or on stage 2.
- R7: With CLEAR_TGT_LSB set (the default), bit 0 of a redirect target is forced to 0 before it is loaded into the fetch address.
- R8: The stage-2 PC always takes the fetch address of the cycle before the edge, including on a flushing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Stage-1 fetch address sent to instruction memory |
| imem_rdata | input | 32 | Instruction word at imem_addr, returned in the same cycle |
| ex_take | input | 1 | Branch comparison outcome from stage 2 |
| ex_target | input | 32 | Control-flow target computed in stage 2 |
| ex_instr | output | 32 | Instruction held for stage 2 |
| ex_pc | output | 32 | Fetch address of the instruction held for stage 2 |

## Verification
Each result is due exactly one rising edge after the stimulus that produces it. The redirect decision, the target and the fetched word are combinational in the cycle before the edge. The next fetch address, stage-2 word and stage-2 PC all appear right after that single edge. The bench therefore applies the branch outcome just after a falling edge and lets the combinational target settle. It then predicts all three outputs from the requirements and the scripted memory, and compares them at the next falling edge. A sweep of several hundred cycles runs a program of branches, both jump kinds and plain ALU words against a rotating branch-outcome pattern, so every opcode class meets both outcome values.

// File: rtl/fe2_pkg.sv
package fe2_pkg;
   localparam int unsigned ILEN = 32;
   localparam logic [ILEN-1:0] NOP_WORD = 32'h0000_0013;

   localparam logic [6:0] OPC_BRANCH = 7'h63;
   localparam logic [6:0] OPC_JAL    = 7'h6F;
   localparam logic [6:0] OPC_JALR   = 7'h67;

   typedef enum logic [1:0] {
      CF_NONE   = 2'd0,
      CF_BRANCH = 2'd1,
      CF_JUMP   = 2'd2
   } cf_kind_e;

   function automatic cf_kind_e classify(input logic [6:0] opc);
      case (opc)
         OPC_BRANCH:        return CF_BRANCH;
         OPC_JAL, OPC_JALR: return CF_JUMP;
         default:           return CF_NONE;
      endcase
   endfunction
endpackage

// File: rtl/fe2_cf_decode.sv
module fe2_cf_decode
   import fe2_pkg::*;
(
   input  logic [6:0] opcode,
   input  logic       take,
   output logic       redirect
);
   cf_kind_e kind;

   always_comb begin
      kind = classify(opcode);
      unique case (kind)
         CF_JUMP:   redirect = 1'b1;
         CF_BRANCH: redirect = take;
         default:   redirect = 1'b0;
      endcase
   end
endmodule

// File: rtl/fe2_pc_gen.sv
module fe2_pc_gen #(
   parameter int unsigned     XLEN          = 32,
   parameter int unsigned     STEP          = 4,
   parameter logic [XLEN-1:0] RESET_PC      = '0,
   parameter bit              CLEAR_TGT_LSB = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            redirect,
   input  logic [XLEN-1:0] target,
   output logic [XLEN-1:0] pc
);
   localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

   logic [XLEN-1:0] tgt_q;
   logic [XLEN-1:0] pc_nxt;

   generate
      if (CLEAR_TGT_LSB) begin : g_tgt_clear
         assign tgt_q = {target[XLEN-1:1], 1'b0};
      end else begin : g_tgt_raw
         assign tgt_q = target;
      end
   endgenerate

   always_comb begin
      pc_nxt = redirect ? tgt_q : pc + STEP_V;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc <= RESET_PC;
      else        pc <= pc_nxt;
   end
endmodule

// File: rtl/fe2_stage_reg.sv
module fe2_stage_reg
   import fe2_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic [ILEN-1:0] fetch_instr,
   input  logic [XLEN-1:0] fetch_pc,
   output logic [ILEN-1:0] ex_instr,
   output logic [XLEN-1:0] ex_pc
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ex_instr <= NOP_WORD;
         ex_pc    <= '0;
      end else begin
         ex_instr <= flush ? NOP_WORD : fetch_instr;
         ex_pc    <= fetch_pc;
      end
   end
endmodule

// File: rtl/fe2_pipe_front.sv
module fe2_pipe_front
   import fe2_pkg::*;
#(
   parameter int unsigned     XLEN          = 32,
   parameter int unsigned     STEP          = 4,
   parameter logic [XLEN-1:0] RESET_PC      = '0,
   parameter bit              CLEAR_TGT_LSB = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] imem_addr,
   input  logic [ILEN-1:0] imem_rdata,
   input  logic            ex_take,
   input  logic [XLEN-1:0] ex_target,
   output logic [ILEN-1:0] ex_instr,
   output logic [XLEN-1:0] ex_pc
);
   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("fe2_pipe_front: XLEN must be at least 32");
      end
      if (STEP == 0 || (STEP % 2) != 0) begin : g_bad_step
         $error("fe2_pipe_front: STEP must be a nonzero even value");
      end
   endgenerate

   logic redirect;

   fe2_cf_decode u_dec (
      .opcode   (ex_instr[6:0]),
      .take     (ex_take),
      .redirect (redirect)
   );

   fe2_pc_gen #(
      .XLEN          (XLEN),
      .STEP          (STEP),
      .RESET_PC      (RESET_PC),
      .CLEAR_TGT_LSB (CLEAR_TGT_LSB)
   ) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .redirect (redirect),
      .target   (ex_target),
      .pc       (imem_addr)
   );

   fe2_stage_reg #(
      .XLEN (XLEN)
   ) u_sreg (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (redirect),
      .fetch_instr (imem_rdata),
      .fetch_pc    (imem_addr),
      .ex_instr    (ex_instr),
      .ex_pc       (ex_pc)
   );
endmodule

// File: rtl/fe2_pipe_front_chk.sv
module fe2_pipe_front_chk
   import fe2_pkg::*;
#(
   parameter int unsigned XLEN          = 32,
   parameter int unsigned STEP          = 4,
   parameter bit          CLEAR_TGT_LSB = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [XLEN-1:0] imem_addr,
   input logic [ILEN-1:0] imem_rdata,
   input logic            ex_take,
   input logic [XLEN-1:0] ex_target,
   input logic [ILEN-1:0] ex_instr,
   input logic [XLEN-1:0] ex_pc
);
   logic is_jump, is_br;
   assign is_jump = (ex_instr[6:0] == OPC_JAL) || (ex_instr[6:0] == OPC_JALR);
   assign is_br   = (ex_instr[6:0] == OPC_BRANCH);

   p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_jump && !(is_br && ex_take)) |=>
         (imem_addr == $past(imem_addr) + XLEN'(STEP)) && (ex_instr == $past(imem_rdata)));

   p_jump_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_jump |=> (ex_instr == NOP_WORD));

   p_jump_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_jump |=> (imem_addr[XLEN-1:1] == $past(ex_target[XLEN-1:1])));

   p_taken_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_br && ex_take) |=> (ex_instr == NOP_WORD));

   p_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_br && !ex_take) |=> (ex_instr == $past(imem_rdata)));

   p_lsb_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (CLEAR_TGT_LSB && is_jump) |=> (imem_addr[0] == 1'b0));

   p_pc_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (ex_pc == $past(imem_addr)));
endmodule

bind fe2_pipe_front fe2_pipe_front_chk #(
   .XLEN          (XLEN),
   .STEP          (STEP),
   .CLEAR_TGT_LSB (CLEAR_TGT_LSB)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .imem_addr  (imem_addr),
   .imem_rdata (imem_rdata),
   .ex_take    (ex_take),
   .ex_target  (ex_target),
   .ex_instr   (ex_instr),
   .ex_pc      (ex_pc)
);

// File: tb/tb_fe2_pipe_front.sv
module tb_fe2_pipe_front;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] NOP = 32'h0000_0013;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] imem_addr;
   logic [31:0] imem_rdata;
   logic        ex_take;
   logic [31:0] ex_target;
   logic [31:0] ex_instr;
   logic [31:0] ex_pc;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] prog(input logic [31:0] a);
      int idx;
      idx = int'(a[7:2]);
      if (idx % 9 == 4)       return {25'(idx), 7'h6F};
      else if (idx % 13 == 7) return {25'(idx), 7'h67};
      else if (idx % 4 == 1)  return {25'(idx), 7'h63};
      else if (idx % 6 == 2)  return {25'(idx), 7'h33};
      else                    return {12'(idx), 5'd1, 3'd0, 5'd2, 7'h13};
   endfunction

   function automatic logic [31:0] tgt_of(input logic [31:0] ins, input logic [31:0] pc);
      if (ins[6:0] == 7'h67)      return pc + 32'h21;
      else if (ins[6:0] == 7'h6F) return pc + 32'h40;
      else                        return pc - 32'h18;
   endfunction

   assign imem_rdata = prog(imem_addr);
   assign ex_target  = tgt_of(ex_instr, ex_pc);

   fe2_pipe_front dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .ex_take    (ex_take),
      .ex_target  (ex_target),
      .ex_instr   (ex_instr),
      .ex_pc      (ex_pc)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
      end
   endtask

   initial begin
      logic [31:0] e_pc, e_ir, e_xpc, n_pc, n_ir, tgt;
      logic        redir, br, jmp;
      string       tag;
      rst_n   = 1'b0;
      ex_take = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "reset fetch pc", imem_addr, 32'h0);
      check("R1", "reset stage2 pc", ex_pc, 32'h0);
      check("R1", "reset stage2 instr", ex_instr, NOP);
      rst_n = 1'b1;
      e_pc = 32'h0; e_ir = NOP; e_xpc = 32'h0;
      for (int cyc = 0; cyc < 600; cyc++) begin
         ex_take = ((cyc % 3) != 0);
         #1;
         jmp   = (e_ir[6:0] == 7'h6F) || (e_ir[6:0] == 7'h67);
         br    = (e_ir[6:0] == 7'h63);
         redir = jmp || (br && ex_take);
         tgt   = tgt_of(e_ir, e_xpc);
         tgt[0] = 1'b0;
         n_pc  = redir ? tgt : e_pc + 32'd4;
         n_ir  = redir ? NOP : prog(e_pc);
         if (jmp)                tag = "R3";
         else if (br && ex_take) tag = "R4";
         else if (br)            tag = "R5";
         else if (ex_take)       tag = "R6";
         else                    tag = "R2";
         @(negedge clk);
         check(tag, "fetch pc", imem_addr, n_pc);
         check(tag, "stage2 instr", ex_instr, n_ir);
         check("R8", "stage2 pc", ex_pc, e_pc);
         if (e_ir[6:0] == 7'h67)
            check("R7", "target bit0", {31'b0, imem_addr[0]}, 32'h0);
         e_xpc = e_pc; e_pc = n_pc; e_ir = n_ir;
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule